// File: doc/BRIEF.md
# Receive End-Marker Pairing Formatter

This block sits in the receive clock domain. Upstream is the character decoder, and downstream are the receive credit counter and the receive buffer. Each decoded character arrives with a flag that separates data bytes from end-of-packet markers. A marker is either a normal end or an error end. Data bytes pass straight through behind one output register.

Markers are treated differently, because an empty packet (a marker directly after a marker) can arrive every clock cycle. That is much faster than the downstream logic is built to accept. The block therefore holds a marker for one cycle and waits for a partner:

- If the next cycle brings another marker, both leave as a single transfer with a count of two.
- If the next cycle is idle, or brings a data byte, the held marker leaves alone with a count of one.

Every marker is still accounted for. The credit counter sees one transfer per marker or per pair of markers, so its count at this end of the link stays in step with the other end. Character order is kept exactly: a data byte never overtakes a held marker.

The upstream decoder is assumed never to present a data byte in the cycle directly after another data byte. A data byte spans far more line bits than one clock cycle, so this holds in normal operation.

Top module: `rx_endmark_pairer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is 0 in the following cycle. A marker held at the time of reset is discarded and never appears at the output.
- R2: A data byte (`in_is_mark`=0) that arrives while no marker is held appears in the next cycle with `out_valid`=1, `out_is_mark`=0, `out_pair`=0, `out_mtype`=2'b00 and `out_char` equal to the byte.
- R3: A marker's type is bit 0 of `in_char`: 0 means normal end and 1 means error end. Two markers on consecutive cycles, with none held before them, produce one transfer in the cycle after the second marker. That transfer has `out_is_mark`=1 and `out_pair`=1, with the first marker's type in `out_mtype[0]` and the second marker's type in `out_mtype[1]`.
- R4: A marker followed by an idle cycle produces, in the cycle after the idle one, a transfer with `out_is_mark`=1 and `out_pair`=0. That transfer carries the marker's type in `out_mtype[0]` and 0 in `out_mtype[1]`.
- R5: A marker followed directly by a data byte produces the one-marker transfer in the cycle after the byte. The byte itself follows in the next cycle.
- R6: Marker transfers never occur in two consecutive cycles, so back-to-back markers reach the output at no more than half their arrival rate.
- R7: Over any run of consecutive markers, the counts of the marker transfers (1 or 2 each) add up to the number of markers received. An odd run ends in one single-marker transfer.
- R8: A marker is held for at most one cycle.
- R9: `out_char` is 0 on every marker transfer. The assumed input rule is that no data byte arrives in the cycle after a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded character is present this cycle |
| in_is_mark | input | 1 | 1: end marker, 0: data byte |
| in_char | input | 8 | Data byte, or marker type in bit 0 (1 = error end) |
| out_valid | output | 1 | A transfer is present this cycle |
| out_is_mark | output | 1 | 1: marker transfer, 0: data transfer |
| out_pair | output | 1 | 1: two markers, 0: one marker |
| out_mtype | output | 2 | Marker types: bit 0 first, bit 1 second |
| out_char | output | 8 | Data byte on data transfers, 0 on marker transfers |

## Verification
Latencies are counted from the cycle a character is presented:

| Result | Due in cycle |
|---|---|
| Data byte with no held marker | +1 |
| Pair | +1 after the second marker |
| Lone marker (flushed by idle or by a data byte) | +2 |
| Data byte behind a flushed marker | +2 |

Each scenario task drives its inputs at the falling edge. It then reads the outputs shortly after the next rising edge, so each read shows exactly the register state loaded from the character driven before it. The quiet cycles in between are checked for `out_valid`=0 as well. Long marker runs are summed transfer by transfer, and any two consecutive marker transfers are flagged.

// File: rtl/rx_emp_pkg.sv
// Package: shared types for the receive end-marker pairing formatter.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package rx_emp_pkg;

    // Source of the next output transfer, chosen each cycle by the top level.
    typedef enum logic [2:0] {
        EMIT_NONE    = 3'd0,  // no transfer
        EMIT_IN_DATA = 3'd1,  // the data byte on the input this cycle
        EMIT_STASH   = 3'd2,  // the data byte parked behind a flushed marker
        EMIT_SINGLE  = 3'd3,  // the held marker alone
        EMIT_PAIR    = 3'd4   // the held marker plus the input marker
    } emit_e;

endpackage

// File: rtl/rx_emp_hold.sv
// Module: rx_emp_hold
// Holds at most one end marker (its type bit) while the formatter waits
// one cycle for a second marker to pair it with.
// Assumes: the controller never loads while a marker is already held and
// always clears a held marker on the cycle after it was loaded.
module rx_emp_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_type,
    input  logic clear,
    output logic pend_v,
    output logic pend_type
);

    // Purpose: capture a new marker, or release the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_type <= 1'b0;
        end else if (load) begin
            pend_v    <= 1'b1;
            pend_type <= load_type;
        end else if (clear) begin
            pend_v    <= 1'b0;
            pend_type <= 1'b0;
        end
    end

    AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |=> !pend_v); // R8

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |-> !load); // R7

endmodule

// File: rtl/rx_emp_stash.sv
// Module: rx_emp_stash
// Parks one data byte for a single cycle. This covers the case where the
// byte arrives just as a held marker must be flushed ahead of it.
// Assumes: no data byte arrives in the cycle after another data byte, so
// the parked byte is always free to leave on the following cycle.
module rx_emp_stash #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              stash_v,
    output logic [DATA_W-1:0] stash_d
);

    // Purpose: keep a byte for exactly one cycle after it is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stash_v <= 1'b0;
            stash_d <= '0;
        end else begin
            stash_v <= load;
            if (load) begin
                stash_d <= load_data;
            end
        end
    end

    AST_STASH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stash_v |=> !stash_v); // R5

endmodule

// File: rtl/rx_emp_outstage.sv
// Module: rx_emp_outstage
// Builds the next transfer from the selected source and registers it, so
// that every output of the formatter comes straight from a flip-flop.
// Assumes: the emit code selects a source that holds valid data.
module rx_emp_outstage
    import rx_emp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  emit_e             emit,
    input  logic [DATA_W-1:0] in_char,
    input  logic              in_type,
    input  logic [DATA_W-1:0] stash_d,
    input  logic              pend_type,
    output logic              out_valid,
    output logic              out_is_mark,
    output logic              out_pair,
    output logic [1:0]        out_mtype,
    output logic [DATA_W-1:0] out_char
);

    logic              nx_valid;
    logic              nx_mark;
    logic              nx_pair;
    logic [1:0]        nx_mtype;
    logic [DATA_W-1:0] nx_char;

    // Purpose: decode the emit code into the next transfer's fields.
    always_comb begin
        nx_valid = 1'b0;
        nx_mark  = 1'b0;
        nx_pair  = 1'b0;
        nx_mtype = 2'b00;
        nx_char  = '0;
        case (emit)
            EMIT_IN_DATA: begin
                nx_valid = 1'b1;
                nx_char  = in_char;
            end
            EMIT_STASH: begin
                nx_valid = 1'b1;
                nx_char  = stash_d;
            end
            EMIT_SINGLE: begin
                nx_valid = 1'b1;
                nx_mark  = 1'b1;
                nx_mtype = {1'b0, pend_type};
            end
            EMIT_PAIR: begin
                nx_valid = 1'b1;
                nx_mark  = 1'b1;
                nx_pair  = 1'b1;
                nx_mtype = {in_type, pend_type};
            end
            default: begin
                nx_valid = 1'b0;
            end
        endcase
    end

    // Purpose: register the transfer; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_is_mark <= 1'b0;
            out_pair    <= 1'b0;
            out_mtype   <= 2'b00;
            out_char    <= '0;
        end else begin
            out_valid   <= nx_valid;
            out_is_mark <= nx_mark;
            out_pair    <= nx_pair;
            out_mtype   <= nx_mtype;
            out_char    <= nx_char;
        end
    end

    AST_MARK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_mark) |=> !(out_valid && out_is_mark)); // R6

    AST_MARK_CHAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_mark) |-> (out_char == '0)); // R9

    AST_SINGLE_SECOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_mark && !out_pair) |-> !out_mtype[1]); // R4

endmodule

// File: rtl/rx_endmark_pairer.sv
// Module: rx_endmark_pairer (top)
// Receive-side formatter between the character decoder and the credit
// counter and buffer. Data bytes pass through one register. End markers
// are held for one cycle and merged in pairs when they arrive back to
// back. Each marker is still counted once, and character order is kept.
// Assumes: synchronous active-low reset; the decoder never presents a
// data byte in the cycle after another data byte.
module rx_endmark_pairer
    import rx_emp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TYPE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_mark,
    input  logic [DATA_W-1:0] in_char,
    output logic              out_valid,
    output logic              out_is_mark,
    output logic              out_pair,
    output logic [1:0]        out_mtype,
    output logic [DATA_W-1:0] out_char
);

    localparam int TB = (TYPE_BIT < DATA_W) ? TYPE_BIT : 0;

    emit_e emit;
    logic  pend_v;
    logic  pend_type;
    logic  pend_load;
    logic  pend_clear;
    logic  stash_v;
    logic  stash_load;
    logic  in_type;
    logic [DATA_W-1:0] stash_d;

    assign in_type = in_char[TB];

    // Purpose: choose the next transfer source and update the hold and stash.
    always_comb begin
        emit       = EMIT_NONE;
        pend_load  = 1'b0;
        pend_clear = 1'b0;
        stash_load = 1'b0;
        if (in_valid && in_is_mark) begin
            if (pend_v) begin
                emit       = EMIT_PAIR;
                pend_clear = 1'b1;
            end else begin
                pend_load = 1'b1;
                if (stash_v) begin
                    emit = EMIT_STASH;
                end
            end
        end else if (in_valid) begin
            if (pend_v) begin
                emit       = EMIT_SINGLE;
                pend_clear = 1'b1;
                stash_load = 1'b1;
            end else begin
                emit = EMIT_IN_DATA;
            end
        end else begin
            if (pend_v) begin
                emit       = EMIT_SINGLE;
                pend_clear = 1'b1;
            end else if (stash_v) begin
                emit = EMIT_STASH;
            end
        end
    end

    rx_emp_hold hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pend_load),
        .load_type (in_type),
        .clear     (pend_clear),
        .pend_v    (pend_v),
        .pend_type (pend_type)
    );

    rx_emp_stash #(.DATA_W(DATA_W)) stash_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (stash_load),
        .load_data (in_char),
        .stash_v   (stash_v),
        .stash_d   (stash_d)
    );

    rx_emp_outstage #(.DATA_W(DATA_W)) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .emit        (emit),
        .in_char     (in_char),
        .in_type     (in_type),
        .stash_d     (stash_d),
        .pend_type   (pend_type),
        .out_valid   (out_valid),
        .out_is_mark (out_is_mark),
        .out_pair    (out_pair),
        .out_mtype   (out_mtype),
        .out_char    (out_char)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_DATA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_mark && !pend_v) |=>
            (out_valid && !out_is_mark && out_char == $past(in_char))); // R2

    AST_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_mark && pend_v) |=> (out_valid && out_is_mark && out_pair)); // R3

    AST_INPUT_DATA_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_mark) |=> !(in_valid && !in_is_mark)); // R9

endmodule

// File: tb/rx_endmark_pairer_tb.sv
module rx_endmark_pairer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_is_mark = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic       out_valid;
    logic       out_is_mark;
    logic       out_pair;
    logic [1:0] out_mtype;
    logic [7:0] out_char;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rx_endmark_pairer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_is_mark  (in_is_mark),
        .in_char     (in_char),
        .out_valid   (out_valid),
        .out_is_mark (out_is_mark),
        .out_pair    (out_pair),
        .out_mtype   (out_mtype),
        .out_char    (out_char)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
            finish_run();
        end
    end

    // Drive one input cycle at the falling edge, then sample just after the rising edge.
    task automatic step(input logic v, input logic m, input logic [7:0] c);
        @(negedge clk);
        in_valid   = v;
        in_is_mark = m;
        in_char    = c;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic ev, input logic em,
                       input logic ep, input logic [1:0] et, input logic [7:0] ec);
        logic ok;
        n_checks = n_checks + 1;
        if (!ev) ok = (out_valid == 1'b0);
        else ok = (out_valid == 1'b1) && (out_is_mark == em) && (out_pair == ep)
                  && (out_mtype == et) && (out_char == ec);
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual v=%b m=%b p=%b t=%b c=%h, expected v=%b m=%b p=%b t=%b c=%h",
                     req, out_valid, out_is_mark, out_pair, out_mtype, out_char,
                     ev, em, ep, et, ec);
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        step(1'b0, 1'b0, 8'h00);
        chk("R1 reset state", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        chk("R1 idle after reset", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
    endtask

    task automatic t_data_pass();
        step(1'b1, 1'b0, 8'hA5);
        chk("R2 data A5", 1'b1, 1'b0, 1'b0, 2'b00, 8'hA5);
        step(1'b0, 1'b0, 8'h00);
        chk("R2 idle after data", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        step(1'b1, 1'b0, 8'h01);
        chk("R2 data 01", 1'b1, 1'b0, 1'b0, 2'b00, 8'h01);
        step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_pair();
        step(1'b1, 1'b1, 8'h00);
        chk("R3 first marker held", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        step(1'b1, 1'b1, 8'h01);
        chk("R3 pair EOP,EEP", 1'b1, 1'b1, 1'b1, 2'b10, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        chk("R3 idle after pair", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        step(1'b1, 1'b1, 8'h01);
        step(1'b1, 1'b1, 8'h00);
        chk("R3 pair EEP,EOP", 1'b1, 1'b1, 1'b1, 2'b01, 8'h00);
        step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_single_idle();
        step(1'b1, 1'b1, 8'h01);
        chk("R4 marker held", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        chk("R4 single EEP", 1'b1, 1'b1, 1'b0, 2'b01, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        chk("R8 no repeat", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
    endtask

    task automatic t_single_data();
        step(1'b1, 1'b1, 8'h00);
        step(1'b1, 1'b0, 8'h3C);
        chk("R5 single before data", 1'b1, 1'b1, 1'b0, 2'b00, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        chk("R5 data after marker", 1'b1, 1'b0, 1'b0, 2'b00, 8'h3C);
        step(1'b0, 1'b0, 8'h00);
        chk("R5 quiet after", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        // marker, data, marker, marker: stash leaves while the new marker is held
        step(1'b1, 1'b1, 8'h01);
        step(1'b1, 1'b0, 8'h77);
        chk("R5 single EEP before data", 1'b1, 1'b1, 1'b0, 2'b01, 8'h00);
        step(1'b1, 1'b1, 8'h00);
        chk("R5 data 77 while marker held", 1'b1, 1'b0, 1'b0, 2'b00, 8'h77);
        step(1'b1, 1'b1, 8'h01);
        chk("R7 pair after stash", 1'b1, 1'b1, 1'b1, 2'b10, 8'h00);
        step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_long_run(input int n);
        int  total = 0;
        bit  prev_mark = 1'b0;
        int  spacing_err = 0;
        for (int i = 0; i < n + 3; i++) begin
            if (i < n) step(1'b1, 1'b1, 8'(i % 2));
            else       step(1'b0, 1'b0, 8'h00);
            if (out_valid && out_is_mark) begin
                total = total + (out_pair ? 2 : 1);
                if (prev_mark) spacing_err = spacing_err + 1;
                prev_mark = 1'b1;
            end else begin
                prev_mark = 1'b0;
            end
        end
        n_checks = n_checks + 1;
        if (total != n) begin
            n_fail = n_fail + 1;
            $display("FAIL R7 marker total: actual %0d, expected %0d", total, n);
        end
        n_checks = n_checks + 1;
        if (spacing_err != 0) begin
            n_fail = n_fail + 1;
            $display("FAIL R6 back-to-back marker transfers: actual %0d, expected 0", spacing_err);
        end
    endtask

    task automatic t_reset_drop();
        step(1'b1, 1'b1, 8'h01);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 8'h00);
        chk("R1 held marker dropped in reset", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        chk("R1 no marker after reset", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        chk("R1 still quiet", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_data_pass();
        t_pair();
        t_single_idle();
        t_single_data();
        t_long_run(7);
        t_long_run(10);
        t_reset_drop();
        finish_run();
    end

endmodule